// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

A single-port synchronous static RAM for second-level cache data, organised as 18-bit words: 16 data bits and 2 parity bits. The address width is a parameter. The default of 10 bits keeps elaboration small, and a setting of 16 gives the full 64K-word array. The shared bidirectional data bus is presented as separate input, output and per-lane drive-enable signals. The pad three-state drivers sit outside the block.

An access starts when chip select is low and at least one of two address strobes is low at a rising clock edge. A start through the processor strobe ignores the write enables in that cycle, so the tag logic has one cycle to approve a write. The write then lands at the following edge. A start through the controller strobe writes in the same cycle when a write enable is low.

After the address is loaded, an advance input steps a 2-bit wraparound counter through a four-beat burst. The address bits above the counter stay fixed during the burst. A parameter selects one of two beat orders:
- XOR (interleaved) order, the default.
- Modulo-4 incrementing (linear) order.

Read data is registered. The bus is driven only when output enable is low and that lane's write enable is high.

Top module: `sram_burst_cache`

## Requirements
- R1: After reset, and until the first access starts, `dq_oe_o` is 2'b00 and `dq_o` is all zero.
- R2: While `cs_ni` is high, neither strobe loads an address. A burst already in progress keeps its address.
- R3: At an edge where `cs_ni` is low, `strb_cpu_ni` is high, `strb_ctl_ni` is low and at least one write enable is low, the enabled lanes of `dq_i` are written to `addr_i` at that edge.
- R4: At an edge where `cs_ni` and `strb_cpu_ni` are low, the write enables are ignored and `addr_i` is loaded. At the next edge with no start, each lane whose write enable is low is written from `dq_i` to the held burst address.
- R5: At an edge that starts an access with both write enables high, the word at `addr_i` appears on `dq_o` just after that edge.
- R6: Lane 0 (`we_lo_ni`) covers data bits 7:0 and bit 16. Lane 1 (`we_hi_ni`) covers data bits 15:8 and bit 17. A lane whose enable is high keeps its stored value.
- R7: `dq_oe_o[k]` is high only when `oe_ni` is low, the lane k write enable is high, and the last edge that accessed the array was a read.
- R8: At an edge with no start, an active burst, `adv_ni` low and both write enables high, the counter steps and the next beat's word is read. With `adv_ni` high the counter holds and the same word is read again.
- R9: With `ORDER` = interleaved, beat n uses low address bits equal to the first low bits XOR n.
- R10: With `ORDER` = linear, beat n uses low address bits equal to the first low bits plus n, modulo 4.
- R11: Address bits above bit 1 keep their loaded value through all four beats, including wraparound.
- R12: When both strobes are low with `cs_ni` low, the processor strobe takes priority and no write happens at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| strb_cpu_ni | input | 1 | Processor address strobe, active low |
| strb_ctl_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| we_lo_ni | input | 1 | Lane 0 write enable, active low |
| we_hi_ni | input | 1 | Lane 1 write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | 18 | Bus value driven toward the array |
| dq_o | output | 18 | Registered read data |
| dq_oe_o | output | 2 | Per-lane drive enable for the bus |

## Verification
The checker watches, on every cycle:
- the counter load on a start;
- counter stepping and holding;
- chip select blocking the strobes;
- the absence of any lane write in a processor-strobe cycle;
- the same-edge write of a controller-strobe start;
- the drive-enable gating.

The actual stored contents, byte-lane isolation, the two beat orders, wraparound within the fixed upper address, and the delayed processor-strobe write can only be shown by the bench scenarios. Those scenarios read words back against a bench-side memory model for both orderings.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  localparam int LANES  = 2;
  localparam int BYTE_W = 8;
  localparam int LANE_W = BYTE_W + 1;
  localparam int WORD_W = LANES * LANE_W;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_INTERLEAVED = 1'b0,
    ORD_LINEAR      = 1'b1
  } burst_ord_e;

  function automatic logic [BEAT_W-1:0] beat_offs(burst_ord_e ord,
                                                  logic [BEAT_W-1:0] first,
                                                  logic [BEAT_W-1:0] n);
    return (ord == ORD_LINEAR) ? BEAT_W'(first + n) : (first ^ n);
  endfunction
endpackage

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
  import sram_burst_pkg::*;
(
  input  logic             cs_ni,
  input  logic             strb_cpu_ni,
  input  logic             strb_ctl_ni,
  input  logic [LANES-1:0] we_ni,
  input  logic             active_i,
  output logic             start_o,
  output logic             wr_o,
  output logic             rd_o,
  output logic             cur_sel_o,
  output logic [LANES-1:0] lane_wr_o
);
  logic any_we, ctl_wr, cont;

  assign any_we  = ~&we_ni;
  assign start_o = ~cs_ni & (~strb_cpu_ni | ~strb_ctl_ni);
  // processor strobe wins: write enables ignored in its cycle
  assign ctl_wr  = ~cs_ni & strb_cpu_ni & ~strb_ctl_ni & any_we;
  assign cont    = ~start_o & active_i;

  assign wr_o      = ctl_wr | (cont & any_we);
  assign rd_o      = (start_o & ~ctl_wr) | (cont & ~any_we);
  assign cur_sel_o = cont & any_we;
  assign lane_wr_o = wr_o ? ~we_ni : '0;
endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr
  import sram_burst_pkg::*;
#(
  parameter int         ADDR_W = 10,
  parameter burst_ord_e ORDER  = ORD_INTERLEAVED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              adv_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              active_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] nxt_addr_o,
  output logic [BEAT_W-1:0] cnt_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [HI_W-1:0]   base_q, base_d;
  logic [BEAT_W-1:0] first_q, first_d, cnt_q, cnt_d;
  logic              active_q, step;

  assign step = ~start_i & active_q & ~adv_ni;

  always_comb begin
    base_d  = base_q;
    first_d = first_q;
    cnt_d   = cnt_q;
    if (start_i) begin
      base_d  = addr_i[ADDR_W-1:BEAT_W];
      first_d = addr_i[BEAT_W-1:0];
      cnt_d   = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      first_q  <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      base_q   <= base_d;
      first_q  <= first_d;
      cnt_q    <= cnt_d;
      active_q <= active_q | start_i;
    end
  end

  assign cur_addr_o = {base_q, beat_offs(ORDER, first_q, cnt_q)};
  assign nxt_addr_o = {base_d, beat_offs(ORDER, first_d, cnt_d)};
  assign active_o   = active_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/sram_burst_lane.sv
module sram_burst_lane #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_q [DEPTH];
  logic [LANE_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sram_burst_cache.sv
module sram_burst_cache
  import sram_burst_pkg::*;
#(
  parameter int         ADDR_W = 10,
  parameter burst_ord_e ORDER  = ORD_INTERLEAVED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              strb_cpu_ni,
  input  logic              strb_ctl_ni,
  input  logic              adv_ni,
  input  logic              we_lo_ni,
  input  logic              we_hi_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] dq_i,
  output logic [WORD_W-1:0] dq_o,
  output logic [LANES-1:0]  dq_oe_o
);
  logic [LANES-1:0]  we_n, lane_wr;
  logic              start, wr, rd, cur_sel, active, rd_valid_q;
  logic [ADDR_W-1:0] cur_addr, nxt_addr, acc_addr;
  logic [BEAT_W-1:0] cnt;

  assign we_n = {we_hi_ni, we_lo_ni};

  sram_burst_ctl u_ctl (
    .cs_ni       (cs_ni),
    .strb_cpu_ni (strb_cpu_ni),
    .strb_ctl_ni (strb_ctl_ni),
    .we_ni       (we_n),
    .active_i    (active),
    .start_o     (start),
    .wr_o        (wr),
    .rd_o        (rd),
    .cur_sel_o   (cur_sel),
    .lane_wr_o   (lane_wr)
  );

  sram_burst_addr #(.ADDR_W(ADDR_W), .ORDER(ORDER)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .adv_ni     (adv_ni),
    .addr_i     (addr_i),
    .active_o   (active),
    .cur_addr_o (cur_addr),
    .nxt_addr_o (nxt_addr),
    .cnt_o      (cnt)
  );

  // delayed write hits the held beat; everything else uses the post-edge address
  assign acc_addr = cur_sel ? cur_addr : nxt_addr;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] wdata, rdata;

    assign wdata = {dq_i[LANES*BYTE_W+k], dq_i[k*BYTE_W +: BYTE_W]};

    sram_burst_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (lane_wr[k]),
      .rd_i    (rd),
      .addr_i  (acc_addr),
      .wdata_i (wdata),
      .rdata_o (rdata)
    );

    assign dq_o[k*BYTE_W +: BYTE_W] = rdata[BYTE_W-1:0];
    assign dq_o[LANES*BYTE_W+k]     = rdata[BYTE_W];
    assign dq_oe_o[k]               = ~oe_ni & we_n[k] & rd_valid_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rd_valid_q <= 1'b0;
    else if (rd)  rd_valid_q <= 1'b1;
    else if (wr)  rd_valid_q <= 1'b0;
  end
endmodule

// File: rtl/sram_burst_chk.sv
module sram_burst_chk
  import sram_burst_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              strb_cpu_ni,
  input logic              strb_ctl_ni,
  input logic              adv_ni,
  input logic              we_lo_ni,
  input logic              we_hi_ni,
  input logic              oe_ni,
  input logic              active_i,
  input logic [BEAT_W-1:0] cnt_i,
  input logic [LANES-1:0]  lane_wr_i,
  input logic [LANES-1:0]  dq_oe_o
);
  logic any_start;
  assign any_start = ~cs_ni & (~strb_cpu_ni | ~strb_ctl_ni);

  p_oe_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> dq_oe_o == '0);

  p_oe_lane_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_lo_ni |-> !dq_oe_o[0]) and (!we_hi_ni |-> !dq_oe_o[1]));

  p_cs_block_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && active_i && adv_ni) |=> $stable(cnt_i));

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_start |=> (cnt_i == '0) && active_i);

  p_adv_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_start && active_i && !adv_ni) |=> cnt_i == BEAT_W'($past(cnt_i) + 1'b1));

  p_adv_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_start && adv_ni) |=> $stable(cnt_i));

  p_cpu_no_wr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !strb_cpu_ni) |-> lane_wr_i == '0);

  p_ctl_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && strb_cpu_ni && !strb_ctl_ni)
      |-> lane_wr_i == {~we_hi_ni, ~we_lo_ni});

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> lane_wr_i == '0 || any_start);
endmodule

bind sram_burst_cache sram_burst_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .strb_cpu_ni (strb_cpu_ni),
  .strb_ctl_ni (strb_ctl_ni),
  .adv_ni      (adv_ni),
  .we_lo_ni    (we_lo_ni),
  .we_hi_ni    (we_hi_ni),
  .oe_ni       (oe_ni),
  .active_i    (active),
  .cnt_i       (cnt),
  .lane_wr_i   (lane_wr),
  .dq_oe_o     (dq_oe_o)
);

// File: tb/sram_burst_cache_tb.sv
module sram_burst_cache_tb;
  import sram_burst_pkg::*;

  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1;
  logic wlo_n = 1'b1, whi_n = 1'b1, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [17:0] din = '0, dq_o_i, dq_o_l;
  logic [1:0]  oe_i, oe_l;

  always #10 clk = ~clk;

  sram_burst_cache #(.ADDR_W(AW), .ORDER(ORD_INTERLEAVED)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .strb_cpu_ni(cpu_n),
    .strb_ctl_ni(ctl_n), .adv_ni(adv_n), .we_lo_ni(wlo_n), .we_hi_ni(whi_n),
    .oe_ni(oe_n), .addr_i(addr), .dq_i(din), .dq_o(dq_o_i), .dq_oe_o(oe_i));

  sram_burst_cache #(.ADDR_W(AW), .ORDER(ORD_LINEAR)) u_dut_lin (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .strb_cpu_ni(cpu_n),
    .strb_ctl_ni(ctl_n), .adv_ni(adv_n), .we_lo_ni(wlo_n), .we_hi_ni(whi_n),
    .oe_ni(oe_n), .addr_i(addr), .dq_i(din), .dq_o(dq_o_l), .dq_oe_o(oe_l));

  int n_pass = 0, n_tot = 0;
  bit done = 1'b0;

  // bench model (requirements R3..R11)
  logic [17:0] m_i [DEPTH];
  logic [17:0] m_l [DEPTH];
  logic [AW-3:0] m_base = '0;
  logic [1:0] m_first = '0, m_cnt = '0;
  logic m_act = 1'b0, m_rdv = 1'b0;

  logic [35:0] q_exp[$];
  string       q_tag[$];

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_tot++;
    if (ok) n_pass++;
    else $display("FAIL %s: actual %h expected %h", req, act, exp);
  endtask

  function automatic logic [17:0] wr_lanes(logic [17:0] old, logic [17:0] d, logic wlo, logic whi);
    logic [17:0] r = old;
    if (!wlo) begin r[7:0] = d[7:0];   r[16] = d[16]; end
    if (!whi) begin r[15:8] = d[15:8]; r[17] = d[17]; end
    return r;
  endfunction

  task automatic cyc(input logic cs, cpu, ctl, adv, wlo, whi, oe,
                     input logic [AW-1:0] a, input logic [17:0] d, input string tag);
    logic st, ctlw, cont, wr, rd;
    logic [AW-1:0] cur_i, cur_l, wa_i, wa_l, nx_i, nx_l;
    logic [1:0] exp_oe;
    @(negedge clk);
    cs_n = cs; cpu_n = cpu; ctl_n = ctl; adv_n = adv;
    wlo_n = wlo; whi_n = whi; oe_n = oe; addr = a; din = d;
    #1;
    exp_oe = {~oe & whi & m_rdv, ~oe & wlo & m_rdv};
    chk(oe_i === exp_oe, "R7", 36'(oe_i), 36'(exp_oe));
    st   = !cs && (!cpu || !ctl);
    ctlw = !cs && cpu && !ctl && !(wlo && whi);
    cont = !st && m_act;
    wr   = ctlw || (cont && !(wlo && whi));
    rd   = (st && !ctlw) || (cont && wlo && whi);
    cur_i = {m_base, m_first ^ m_cnt};
    cur_l = {m_base, 2'(m_first + m_cnt)};
    wa_i = st ? a : cur_i;
    wa_l = st ? a : cur_l;
    if (st) begin
      m_base = a[AW-1:2]; m_first = a[1:0]; m_cnt = '0; m_act = 1'b1;
    end else if (cont && !adv) begin
      m_cnt = m_cnt + 2'd1;
    end
    if (wr) begin
      m_i[wa_i] = wr_lanes(m_i[wa_i], d, wlo, whi);
      m_l[wa_l] = wr_lanes(m_l[wa_l], d, wlo, whi);
    end
    nx_i = {m_base, m_first ^ m_cnt};
    nx_l = {m_base, 2'(m_first + m_cnt)};
    m_rdv = rd ? 1'b1 : (wr ? 1'b0 : m_rdv);
    @(posedge clk);
    if (rd) begin
      q_exp.push_back({m_i[nx_i], m_l[nx_l]});
      q_tag.push_back(tag);
    end
  endtask

  // monitor: compare registered read data against the scoreboard
  always @(posedge clk) begin
    #5;
    while (q_exp.size() > 0) begin
      logic [35:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      chk(dq_o_i === e[35:18], t, 36'(dq_o_i), 36'(e[35:18]));
      chk(dq_o_l === e[17:0], {t, " lin"}, 36'(dq_o_l), 36'(e[17:0]));
    end
  end

  task automatic ctl_wr(input logic [AW-1:0] a, input logic [17:0] d, input logic wlo, whi, input string tag);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, wlo, whi, 1'b0, a, d, tag);
  endtask
  task automatic ctl_rd(input logic [AW-1:0] a, input string tag);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, a, '0, tag);
  endtask
  task automatic cpu_rd(input logic [AW-1:0] a, input string tag);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, a, '0, tag);
  endtask
  task automatic advance(input string tag);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, '0, tag);
  endtask
  task automatic hold(input string tag);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, '0, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tot++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_pass, n_tot);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_i[i] = '0; m_l[i] = '0; end
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk(oe_i === 2'b00 && oe_l === 2'b00, "R1", 36'({oe_i, oe_l}), 36'(0));
    chk(dq_o_i === '0 && dq_o_l === '0, "R1", {dq_o_i, dq_o_l}, 36'(0));

    // R3: fill two regions through the controller strobe
    for (int k = 0; k < 4; k++) ctl_wr(AW'(10'h040 + k), 18'h1_0000 * (k % 4) + 18'h0A50 + 18'(k * 18'h1111), 1'b0, 1'b0, "R3");
    for (int k = 0; k < 8; k++) ctl_wr(AW'(10'h100 + k), 18'h2_C300 + 18'(k * 18'h0101), 1'b0, 1'b0, "R3");

    // R5: single read, data one edge later; drive enables follow (R7)
    ctl_rd(10'h040, "R5");
    hold("R5");
    ctl_rd(10'h105, "R5");

    // R9/R10: burst from 0x042 with four advances (wrap)
    cpu_rd(10'h042, "R9");
    advance("R9"); advance("R9"); advance("R9"); advance("R9");
    // R8: advance high holds
    hold("R8"); hold("R8");
    // R11: start at 0x043, upper bits must stay at 0x040
    cpu_rd(10'h043, "R11");
    advance("R11"); advance("R11"); advance("R11");

    // R2: strobes with chip select high do not reload
    ctl_rd(10'h040, "R2");
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'h105, '0, "R2");
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'h106, '0, "R2");

    // R4: processor write, enables ignored in strobe cycle, written next edge
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h041, 18'h3_DEAD, "R4");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h000, 18'h1_BEEF, "R4");
    ctl_rd(10'h041, "R4");

    // R6: single lanes
    ctl_wr(10'h100, 18'h3_FFAA, 1'b0, 1'b1, "R6");
    ctl_rd(10'h100, "R6");
    ctl_wr(10'h101, 18'h3_7755, 1'b1, 1'b0, "R6");
    ctl_rd(10'h101, "R6");

    // R7: output enable high, then a lane write enable low during a read burst
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0, "R7");
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'h102, '0, "R7");
    hold("R7");

    // R12: both strobes low, write enables ignored
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'h103, 18'h0_0000, "R12");
    hold("R12");
    ctl_rd(10'h103, "R12");

    hold("R8");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_tot);
    $finish;
  end
endmodule